// File: doc/BRIEF.md
# Mixed-Length Instruction Prefetch Buffer

This block sits between an instruction cache and a decoder in a core whose instructions are either one or two halfwords long. Its own program-counter incrementer issues 8-byte-aligned fetch requests ahead of execution over a valid/ready handshake. Each returned 64-bit beat is split into four halfwords and appended to a circular halfword queue. The queue holds twelve halfwords, enough for six 32-bit instructions.

From the head of the queue the block works out the length of the next two instructions and presents them on two decode slots. Each cycle the decoder says how many of them it takes. A redirect, carrying a branch target, empties the queue and cancels any fetch in flight. Fetching then restarts from the target rounded down to 8 bytes, and the halfwords of the first beat that lie before the target are dropped.

Only one fetch is outstanding at a time. A request is raised only while at least four halfword slots are free, so an accepted beat always fits in the queue.

Top module: `mixlen_prefetch_buf`

## Requirements
- R1: After synchronous reset both decode slots are invalid, `fetch_req_valid` is 1 and `fetch_req_addr` equals `RESET_PC` (default 0).
- R2: `fetch_req_valid` is raised only when no fetch is outstanding or cancelled-but-unreturned and at least four halfword slots are free. Every requested address is 8-byte aligned, and each accepted request (valid and ready, no redirect) advances the address by 8.
- R3: The queue never holds more than `DEPTH_HW` halfwords. No accepted beat is lost or overwritten, so the instruction stream stays intact when the decoder stalls.
- R4: Bit 15 of an instruction's first halfword gives its length: 1 means 32 bits, 0 means 16 bits. A 32-bit instruction is presented as {first halfword, second halfword} with `is32`=1. A 16-bit instruction is presented zero-extended in bits 15:0 with `is32`=0.
- R5: Halfword i of a beat, `fetch_rsp_data[16*i+15:16*i]`, is the halfword at byte offset 2*i from the requested address. Halfwords enter the queue in ascending address order.
- R6: Slot 1 holds the instruction that directly follows slot 0 and is valid only when slot 0 is valid. `dec_take` (0, 1 or 2) removes that many presented instructions at the clock edge. A value above the number of valid slots is limited to that number.
- R7: A 32-bit instruction is presented only when both of its halfwords are in the queue, including one that spans two beats.
- R8: In the cycle after `redirect_valid`, both slots are invalid and `fetch_req_addr` equals the target with bits 2:0 cleared. Any response to a fetch issued before or during the redirect is discarded.
- R9: When the redirect target has bits 2:1 equal to k, the first k halfwords of the first beat accepted after the redirect are dropped. The first presented instruction therefore starts exactly at the target.
- R10: While `fetch_req_valid` is 1 and `fetch_req_ready` is 0, and no redirect occurs, the request stays valid with an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redirect_valid | input | 1 | Branch target strobe; flushes and restarts fetch |
| redirect_addr | input | ADDR_W | Branch target byte address (halfword aligned) |
| fetch_req_valid | output | 1 | Fetch request valid |
| fetch_req_addr | output | ADDR_W | 8-byte-aligned fetch address |
| fetch_req_ready | input | 1 | Cache accepts the request |
| fetch_rsp_valid | input | 1 | Fetch data beat valid |
| fetch_rsp_data | input | 64 | Four halfwords, lowest address in bits 15:0 |
| slot0_valid | output | 1 | First decode slot holds an instruction |
| slot0_is32 | output | 1 | First slot instruction is 32 bits |
| slot0_instr | output | 32 | First slot instruction |
| slot1_valid | output | 1 | Second decode slot holds an instruction |
| slot1_is32 | output | 1 | Second slot instruction is 32 bits |
| slot1_instr | output | 32 | Second slot instruction |
| dec_take | input | 2 | Number of presented instructions consumed this cycle |

## Verification
The instruction stream is drawn from three memory images: all 16-bit, all 32-bit, and a mix whose length bit follows a hash of the address. The uniform images isolate the halfword ordering, while the mix produces every pairing of lengths across the two slots and across beat boundaries. Redirect targets at each of the four offsets within a beat separate correct leading-halfword dropping from off-by-one placement. A target at offset 6 in the 32-bit image, with fetch granted one beat at a time, shows whether a split instruction is held back. Varying cache latency, alternating ready, a stalled decoder, and a second redirect that lands while a fetch is in flight tell apart back-pressure handling, overflow protection and the discarding of stale beats.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  localparam int HW_W      = 16;
  localparam int BEAT_HW   = 4;
  localparam int BEAT_W    = HW_W * BEAT_HW;
  localparam int SKIP_W    = $clog2(BEAT_HW);
  localparam int USED_W    = SKIP_W + 1;
  localparam int LEN_BIT   = HW_W - 1;
  localparam int INSTR_W   = 2 * HW_W;
  localparam int BEAT_B    = BEAT_W / 8;
  localparam int ALIGN_W   = $clog2(BEAT_B);

  typedef logic [HW_W-1:0] hw_t;

  typedef struct packed {
    logic               valid;
    logic               is32;
    logic [INSTR_W-1:0] word;
  } slot_t;

  function automatic logic is_long(input hw_t h);
    return h[LEN_BIT];
  endfunction
endpackage

// File: rtl/pfb_fetch_ctl.sv
module pfb_fetch_ctl
  import pfb_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DEPTH_HW = 12,
  parameter logic [31:0] RESET_PC = 32'h0,
  localparam int         CNT_W    = $clog2(DEPTH_HW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redirect_valid,
  input  logic [ADDR_W-1:0] redirect_addr,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [CNT_W-1:0]  count,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              rsp_accept,
  output logic [SKIP_W-1:0] skip
);
  logic [ADDR_W-1:0] pc;
  logic              busy;   // request accepted, beat not yet back
  logic              stale;  // cancelled request whose beat must be dropped
  logic              fire;

  assign req_valid  = !busy && !stale && (count <= CNT_W'(DEPTH_HW - BEAT_HW));
  assign req_addr   = pc;
  assign fire       = req_valid && req_ready;
  assign rsp_accept = rsp_valid && busy && !redirect_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= {RESET_PC[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
      busy  <= 1'b0;
      stale <= 1'b0;
      skip  <= '0;
    end else if (redirect_valid) begin
      pc    <= {redirect_addr[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
      busy  <= 1'b0;
      stale <= ((stale || busy) && !rsp_valid) || fire;
      skip  <= redirect_addr[ALIGN_W-1:1];
    end else begin
      if (fire) begin
        pc   <= pc + ADDR_W'(BEAT_B);
        busy <= 1'b1;
      end
      if (rsp_valid && busy) begin
        busy <= 1'b0;
        skip <= '0;
      end
      if (rsp_valid && stale) stale <= 1'b0;
    end
  end
endmodule

// File: rtl/pfb_queue.sv
module pfb_queue
  import pfb_pkg::*;
#(
  parameter int  DEPTH_HW = 12,
  localparam int CNT_W    = $clog2(DEPTH_HW + 1),
  localparam int PTR_W    = $clog2(DEPTH_HW),
  localparam int EXT_W    = PTR_W + 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           flush,
  input  logic                           wr_en,
  input  logic [BEAT_W-1:0]              wr_data,
  input  logic [SKIP_W-1:0]              wr_skip,
  input  logic [USED_W-1:0]              rd_used,
  output logic [CNT_W-1:0]               count,
  output logic [BEAT_HW-1:0][HW_W-1:0]   win
);
  function automatic logic [PTR_W-1:0] wrap(input logic [EXT_W-1:0] v);
    logic [EXT_W-1:0] r;
    r = (v >= EXT_W'(DEPTH_HW)) ? v - EXT_W'(DEPTH_HW) : v;
    return r[PTR_W-1:0];
  endfunction

  hw_t               mem [DEPTH_HW];
  logic [PTR_W-1:0]  head;
  logic [PTR_W-1:0]  tail;
  logic [USED_W-1:0] wr_n;

  assign tail = wrap(EXT_W'(head) + EXT_W'(count));
  assign wr_n = wr_en ? USED_W'(BEAT_HW) - USED_W'(wr_skip) : '0;

  always_comb begin
    for (int k = 0; k < BEAT_HW; k++) begin
      win[k] = mem[wrap(EXT_W'(head) + EXT_W'(k))];
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < BEAT_HW; j++) begin
      if (wr_en && (j >= int'(wr_skip))) begin
        mem[wrap(EXT_W'(tail) + EXT_W'(j) - EXT_W'(wr_skip))] <= wr_data[j*HW_W +: HW_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head  <= '0;
      count <= '0;
    end else begin
      head  <= wrap(EXT_W'(head) + EXT_W'(rd_used));
      count <= count - CNT_W'(rd_used) + CNT_W'(wr_n);
    end
  end
endmodule

// File: rtl/pfb_present.sv
module pfb_present
  import pfb_pkg::*;
#(
  parameter int  DEPTH_HW = 12,
  localparam int CNT_W    = $clog2(DEPTH_HW + 1)
) (
  input  logic [CNT_W-1:0]             count,
  input  logic [BEAT_HW-1:0][HW_W-1:0] win,
  input  logic [1:0]                   take,
  output slot_t                        slot0,
  output slot_t                        slot1,
  output logic [USED_W-1:0]            used
);
  logic              len0, len1;
  logic [USED_W-1:0] off1, end1;
  hw_t               a_hw, b_hw;
  logic [1:0]        nvalid, take_eff;

  always_comb begin
    len0 = is_long(win[0]);
    off1 = len0 ? USED_W'(2) : USED_W'(1);
    a_hw = len0 ? win[2] : win[1];
    b_hw = len0 ? win[3] : win[2];
    len1 = is_long(a_hw);
    end1 = off1 + (len1 ? USED_W'(2) : USED_W'(1));

    slot0.valid = (count >= CNT_W'(off1));
    slot0.is32  = len0;
    slot0.word  = len0 ? {win[0], win[1]} : {{HW_W{1'b0}}, win[0]};

    slot1.valid = slot0.valid && (count >= CNT_W'(end1));
    slot1.is32  = len1;
    slot1.word  = len1 ? {a_hw, b_hw} : {{HW_W{1'b0}}, a_hw};

    nvalid   = {1'b0, slot0.valid} + {1'b0, slot1.valid};
    take_eff = (take > nvalid) ? nvalid : take;
    case (take_eff)
      2'd1:    used = off1;
      2'd2:    used = end1;
      default: used = '0;
    endcase
  end
endmodule

// File: rtl/mixlen_prefetch_buf.sv
module mixlen_prefetch_buf
  import pfb_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DEPTH_HW = 12,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redirect_valid,
  input  logic [ADDR_W-1:0] redirect_addr,
  output logic              fetch_req_valid,
  output logic [ADDR_W-1:0] fetch_req_addr,
  input  logic              fetch_req_ready,
  input  logic              fetch_rsp_valid,
  input  logic [63:0]       fetch_rsp_data,
  output logic              slot0_valid,
  output logic              slot0_is32,
  output logic [31:0]       slot0_instr,
  output logic              slot1_valid,
  output logic              slot1_is32,
  output logic [31:0]       slot1_instr,
  input  logic [1:0]        dec_take
);
  localparam int CNT_W = $clog2(DEPTH_HW + 1);

  logic [CNT_W-1:0]             q_count;
  logic                         wr_en;
  logic [SKIP_W-1:0]            skip;
  logic [USED_W-1:0]            used;
  logic [BEAT_HW-1:0][HW_W-1:0] win;
  slot_t                        s0, s1;

  pfb_fetch_ctl #(.ADDR_W(ADDR_W), .DEPTH_HW(DEPTH_HW), .RESET_PC(RESET_PC)) u_ctl (
    .clk(clk), .rst(rst),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .req_ready(fetch_req_ready), .rsp_valid(fetch_rsp_valid),
    .count(q_count), .req_valid(fetch_req_valid), .req_addr(fetch_req_addr),
    .rsp_accept(wr_en), .skip(skip)
  );

  pfb_queue #(.DEPTH_HW(DEPTH_HW)) u_q (
    .clk(clk), .rst(rst), .flush(redirect_valid),
    .wr_en(wr_en), .wr_data(fetch_rsp_data), .wr_skip(skip),
    .rd_used(used), .count(q_count), .win(win)
  );

  pfb_present #(.DEPTH_HW(DEPTH_HW)) u_pres (
    .count(q_count), .win(win), .take(dec_take),
    .slot0(s0), .slot1(s1), .used(used)
  );

  assign slot0_valid = s0.valid;
  assign slot0_is32  = s0.is32;
  assign slot0_instr = s0.word;
  assign slot1_valid = s1.valid;
  assign slot1_is32  = s1.is32;
  assign slot1_instr = s1.word;
endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
  parameter int  ADDR_W   = 32,
  parameter int  DEPTH_HW = 12,
  localparam int CNT_W    = $clog2(DEPTH_HW + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              redirect_valid,
  input logic [ADDR_W-1:0] redirect_addr,
  input logic              fetch_req_valid,
  input logic [ADDR_W-1:0] fetch_req_addr,
  input logic              fetch_req_ready,
  input logic              slot0_valid,
  input logic              slot0_is32,
  input logic [31:0]       slot0_instr,
  input logic              slot1_valid,
  input logic [CNT_W-1:0]  q_count
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    q_count <= CNT_W'(DEPTH_HW));

  p_req_room_r2: assert property (@(posedge clk) disable iff (rst)
    fetch_req_valid |-> q_count <= CNT_W'(DEPTH_HW - 4));

  p_req_align_r2: assert property (@(posedge clk) disable iff (rst)
    fetch_req_valid |-> fetch_req_addr[2:0] == 3'b000);

  p_req_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (fetch_req_valid && fetch_req_ready && !redirect_valid)
      |=> fetch_req_addr == $past(fetch_req_addr) + ADDR_W'(8));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (fetch_req_valid && !fetch_req_ready && !redirect_valid)
      |=> fetch_req_valid && $stable(fetch_req_addr));

  p_flush_r8: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> !slot0_valid && !slot1_valid);

  p_redirect_pc_r8: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> fetch_req_addr == {$past(redirect_addr[ADDR_W-1:3]), 3'b000});

  p_slot_order_r6: assert property (@(posedge clk) disable iff (rst)
    slot1_valid |-> slot0_valid);

  p_straddle_r7: assert property (@(posedge clk) disable iff (rst)
    (slot0_valid && slot0_is32) |-> q_count >= CNT_W'(2));

  p_short_form_r4: assert property (@(posedge clk) disable iff (rst)
    (slot0_valid && !slot0_is32) |-> (slot0_instr[31:16] == 16'h0 && !slot0_instr[15]));
endmodule

bind mixlen_prefetch_buf pfb_checker #(.ADDR_W(ADDR_W), .DEPTH_HW(DEPTH_HW)) u_chk (
  .clk(clk), .rst(rst),
  .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
  .fetch_req_valid(fetch_req_valid), .fetch_req_addr(fetch_req_addr),
  .fetch_req_ready(fetch_req_ready),
  .slot0_valid(slot0_valid), .slot0_is32(slot0_is32), .slot0_instr(slot0_instr),
  .slot1_valid(slot1_valid), .q_count(q_count)
);

// File: tb/tb_mixlen_prefetch_buf.sv
`timescale 1ns/1ps
module tb_mixlen_prefetch_buf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        redirect_valid = 1'b0;
  logic [31:0] redirect_addr = '0;
  logic        fetch_req_valid;
  logic [31:0] fetch_req_addr;
  logic        fetch_req_ready = 1'b0;
  logic        fetch_rsp_valid = 1'b0;
  logic [63:0] fetch_rsp_data = '0;
  logic        slot0_valid, slot0_is32, slot1_valid, slot1_is32;
  logic [31:0] slot0_instr, slot1_instr;
  logic [1:0]  dec_take = 2'd0;

  mixlen_prefetch_buf dut (
    .clk(clk), .rst(rst),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .fetch_req_valid(fetch_req_valid), .fetch_req_addr(fetch_req_addr),
    .fetch_req_ready(fetch_req_ready),
    .fetch_rsp_valid(fetch_rsp_valid), .fetch_rsp_data(fetch_rsp_data),
    .slot0_valid(slot0_valid), .slot0_is32(slot0_is32), .slot0_instr(slot0_instr),
    .slot1_valid(slot1_valid), .slot1_is32(slot1_is32), .slot1_instr(slot1_instr),
    .dec_take(dec_take)
  );

  always #2 clk = ~clk;

  // target[31:16] image[15:14] maxtake[13:12] ready_mode[11:10] latency[9:8] cycles[7:0]
  // image: 0 mixed, 1 all 16-bit, 2 all 32-bit; ready_mode: 0 always, 1 alternate
  localparam int NVEC = 8;
  localparam logic [31:0] VECS [NVEC] = '{
    {16'h0100, 2'd0, 2'd2, 2'd0, 2'd1, 8'd80},
    {16'h0222, 2'd0, 2'd1, 2'd1, 2'd2, 8'd80},
    {16'h0344, 2'd1, 2'd2, 2'd0, 2'd1, 8'd60},
    {16'h0466, 2'd2, 2'd2, 2'd0, 2'd3, 8'd80},
    {16'h0500, 2'd2, 2'd1, 2'd1, 2'd1, 8'd60},
    {16'h0602, 2'd1, 2'd1, 2'd0, 2'd2, 8'd60},
    {16'h0706, 2'd0, 2'd2, 2'd1, 2'd3, 8'd100},
    {16'h0780, 2'd0, 2'd2, 2'd0, 2'd1, 8'd40}
  };

  int          checks = 0, failures = 0, cyc = 0, consumed = 0;
  bit          done = 0, post_redir = 0;
  logic [1:0]  image = 0, maxtake = 0, rdy_mode = 0, lat = 1;
  int          budget = 0;
  bit          pend = 0;
  int          cd = 0;
  logic [31:0] paddr = 0, exp_pc = 0, exp_align = 0;

  function automatic logic [15:0] memhw(input logic [31:0] a);
    logic [14:0] i;
    logic        lb;
    i  = a[15:1];
    lb = (image == 2'd0) ? (i[0] ^ i[2] ^ i[3]) : (image == 2'd2);
    return {lb, i};
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] p);
    logic [15:0] h;
    h = memhw(p);
    return h[15] ? {h, memhw(p + 2)} : {16'h0, h};
  endfunction

  function automatic logic [31:0] exp_len(input logic [31:0] p);
    logic [15:0] h;
    h = memhw(p);
    return h[15] ? 32'd4 : 32'd2;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit do_redir, input logic [31:0] tgt);
    logic        rdy;
    logic [31:0] p0, p1, l0;
    int          nv, tk;
    @(negedge clk);
    cyc++;
    if (post_redir) begin
      chk(!slot0_valid && !slot1_valid, "R8 slots after redirect", {slot0_valid, slot1_valid}, 0);
      chk(fetch_req_addr == exp_align, "R8 restart address", fetch_req_addr, exp_align);
      post_redir = 0;
    end
    redirect_valid = do_redir;
    redirect_addr  = tgt;
    // cache model: one beat back 'lat' cycles after acceptance
    fetch_rsp_valid = 1'b0;
    if (pend) begin
      if (cd <= 1) begin
        fetch_rsp_valid = 1'b1;
        fetch_rsp_data  = {memhw(paddr + 6), memhw(paddr + 4), memhw(paddr + 2), memhw(paddr)};
        pend = 0;
      end else cd--;
    end
    case (rdy_mode)
      2'd0:    rdy = 1'b1;
      2'd1:    rdy = cyc[0];
      default: rdy = (budget > 0);
    endcase
    fetch_req_ready = rdy;
    if (fetch_req_valid && rdy) begin
      pend = 1; paddr = fetch_req_addr; cd = lat;
      if (rdy_mode == 2'd2) budget--;
    end
    // decoder model
    if (do_redir) begin
      dec_take   = 2'd0;
      exp_pc     = {tgt[31:1], 1'b0};
      exp_align  = {tgt[31:3], 3'b000};
      post_redir = 1;
    end else begin
      p0 = exp_pc;
      l0 = exp_len(p0);
      p1 = p0 + l0;
      if (slot0_valid) begin
        chk(slot0_instr == exp_word(p0), "R4 R5 slot0 word", slot0_instr, exp_word(p0));
        chk(slot0_is32 == (l0 == 4), "R4 slot0 length", slot0_is32, (l0 == 4));
      end
      if (slot1_valid) begin
        chk(slot1_instr == exp_word(p1), "R6 slot1 word", slot1_instr, exp_word(p1));
        chk(slot1_is32 == (exp_len(p1) == 4), "R6 slot1 length", slot1_is32, (exp_len(p1) == 4));
      end
      nv = int'(slot0_valid) + int'(slot1_valid);
      tk = (int'(maxtake) < nv) ? int'(maxtake) : nv;
      dec_take = 2'(tk);
      if (tk >= 1) exp_pc = p1;
      if (tk == 2) exp_pc = p1 + exp_len(p1);
      consumed += tk;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 32'h0);
  endtask

  initial begin
    logic [31:0] v, w;
    int          c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!slot0_valid && !slot1_valid, "R1 slots after reset", {slot0_valid, slot1_valid}, 0);
    chk(fetch_req_valid == 1'b1, "R1 request after reset", fetch_req_valid, 1);
    chk(fetch_req_addr == 32'h0, "R1 reset address", fetch_req_addr, 0);

    for (int k = 0; k < NVEC; k++) begin
      v = VECS[k];
      lat = v[9:8]; rdy_mode = v[11:10]; maxtake = v[13:12]; image = v[15:14];
      step(1'b1, {16'h0, v[31:16]});
      c0 = consumed;
      run(int'(v[7:0]));
      chk(consumed > c0 + 8, "R6 R9 stream progress", consumed - c0, 9);
    end

    // R2 R3: stalled decoder fills queue, fetch stops, stream stays intact
    image = 0; rdy_mode = 0; lat = 1; maxtake = 0;
    step(1'b1, 32'h0B00);
    run(20);
    chk(fetch_req_valid == 1'b0, "R2 no request when full", fetch_req_valid, 0);
    chk(slot0_valid && slot1_valid, "R3 full queue presents", {slot0_valid, slot1_valid}, 2'b11);
    maxtake = 2; c0 = consumed;
    run(40);
    chk(consumed > c0 + 10, "R3 drain after stall", consumed - c0, 11);

    // R10: request held without ready
    rdy_mode = 2; budget = 0; maxtake = 0;
    step(1'b1, 32'h0900);
    w = fetch_req_addr;
    run(5);
    chk(fetch_req_valid == 1'b1, "R10 request held", fetch_req_valid, 1);
    chk(fetch_req_addr == 32'h0900, "R10 address held", fetch_req_addr, 32'h0900);

    // R7 R9: 32-bit image, target at offset 6, one beat at a time
    image = 2; lat = 1; budget = 0;
    step(1'b1, 32'h0A06);
    budget = 1;
    run(8);
    chk(slot0_valid == 1'b0, "R7 split instruction held", slot0_valid, 0);
    budget = 1;
    run(6);
    chk(slot0_valid && slot0_is32, "R7 joined instruction", {slot0_valid, slot0_is32}, 2'b11);
    chk(slot0_instr == {memhw(32'h0A06), memhw(32'h0A08)}, "R9 first word at target",
        slot0_instr, {memhw(32'h0A06), memhw(32'h0A08)});
    chk(slot1_valid == 1'b1, "R9 second word present", slot1_valid, 1);

    // R8: redirect while a fetch is in flight
    image = 0; rdy_mode = 0; lat = 3; maxtake = 0;
    step(1'b1, 32'h0C00);
    run(2);
    image = 1; maxtake = 2;
    step(1'b1, 32'h0D02);
    c0 = consumed;
    run(40);
    chk(consumed > c0 + 8, "R8 stream after in-flight redirect", consumed - c0, 9);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end
endmodule